// File: doc/BRIEF.md
# Address-Masked Eight-Pin GPIO Port

This block is an eight-pin general-purpose I/O port with a byte-wide register bus: an address, a write strobe, write data and a registered read data byte. Each pin is set as an input or an output by a direction register. Pin values are read and written through a data window, and the access address works as a per-pin mask. A single bus write can therefore change any subset of outputs without a read-modify-write sequence, and a read returns only the pins it names.

The port drives the pad output value and the pad output enable. The pad inputs pass through a synchronizer before they are read or handed on. Interrupt detection lives in a separate unit. This block holds that unit's configuration bytes, passes on its raw and masked status for reading, and turns writes to the clear offset into a one-cycle clear pulse.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, the direction, output value and the four interrupt configuration bytes are all 0x00, and the read data is 0x00.
- R2: Offset 0x400 is the direction byte. Bit n = 1 makes pin n an output. It can be read back, and pad_oe always equals it.
- R3: Any offset below 0x400 is the data window, and address bit n+2 is the mask bit for pin n. A window write loads pin n's output from write data bit n only when the mask bit is 1 and the pin is an output. Every other pin keeps its output value.
- R4: A window write has no effect on a pin that is set as an input. After the pin is switched to output, it drives the value it held before the write.
- R5: A window read returns 0 in every bit whose mask address bit is 0.
- R6: A masked bit of a window read returns the driven output value for an output pin. For an input pin it returns the pad value after a two-flop synchronizer. A pad change made before edge k appears in read data at edge k+2 at the earliest.
- R7: Offsets 0x404 (level/edge select), 0x408 (both-edge select), 0x40C (polarity) and 0x410 (interrupt enable) are read/write bytes that drive the matching cfg_* outputs.
- R8: Offsets 0x414 and 0x418 read irq_raw and irq_masked. Writes to these offsets change no state.
- R9: A write to 0x41C drives irq_clear with the write data for exactly the next cycle. irq_clear is 0 at all other times, and reads of 0x41C return 0x00.
- R10: Offsets at or above 0x400 that are not listed above, including offsets whose two low address bits are not zero, read 0x00 and ignore writes.
- R11: Read data is registered: bus_rdata after edge k reflects the address presented before edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable (direction) |
| pin_sync | output | 8 | Synchronized pad levels for the detection unit |
| cfg_level_sel | output | 8 | Level (1) or edge (0) sensing per pin |
| cfg_dual_edge | output | 8 | Both-edge sensing per pin |
| cfg_polarity | output | 8 | High/rising (1) or low/falling (0) per pin |
| cfg_irq_en | output | 8 | Interrupt enable per pin |
| irq_clear | output | 8 | One-cycle clear pulse per pin |
| irq_raw | input | 8 | Raw interrupt status from the detection unit |
| irq_masked | input | 8 | Masked interrupt status from the detection unit |

## Verification
The bench builds the port with its default values: eight pins, a twelve-bit address and two synchronizer stages. These values reach every mask address bit from bit 2 to bit 9 and the full upper decode. They also place the configuration offsets inside the address range, so unmapped offsets both above 0x41C and at 0x800 can be tested. The two-stage synchronizer gives an exact, countable pad-to-read latency, and the bench checks both the edge before the new value arrives and the edge where it arrives.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned PORT_WIDTH = 8;
   localparam int unsigned WINDOW_TOP_BIT = 10;
   localparam int unsigned NUM_RW_REGS = 5;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DIR,
      SEL_SENSE,
      SEL_BOTH,
      SEL_POLAR,
      SEL_ENABLE,
      SEL_RAW,
      SEL_MASKED,
      SEL_CLEAR
   } reg_sel_e;

   function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
      reg_sel_e sel;
      case (ofs)
         16'h0400: sel = SEL_DIR;
         16'h0404: sel = SEL_SENSE;
         16'h0408: sel = SEL_BOTH;
         16'h040C: sel = SEL_POLAR;
         16'h0410: sel = SEL_ENABLE;
         16'h0414: sel = SEL_RAW;
         16'h0418: sel = SEL_MASKED;
         16'h041C: sel = SEL_CLEAR;
         default:  sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pad_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_data_window.sv
module gpio_data_window #(
   parameter int unsigned PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            win_hit,
   input  logic            wr_en,
   input  logic [PINS-1:0] pin_mask,
   input  logic [PINS-1:0] wr_data,
   input  logic [PINS-1:0] dir,
   input  logic [PINS-1:0] pins_sync,
   output logic [PINS-1:0] out_q,
   output logic [PINS-1:0] rd_val
);

   logic [PINS-1:0] load_pin;

   for (genvar n = 0; n < PINS; n++) begin : g_pin
      assign load_pin[n] = win_hit & wr_en & pin_mask[n] & dir[n];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           out_q[n] <= 1'b0;
         else if (load_pin[n]) out_q[n] <= wr_data[n];
      end

      always_comb begin
         if (!pin_mask[n]) rd_val[n] = 1'b0;
         else if (dir[n])  rd_val[n] = out_q[n];
         else              rd_val[n] = pins_sync[n];
      end
   end

   // R4: outputs of pins that were inputs never move
   p_input_pin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((out_q ^ $past(out_q)) & ~$past(dir)) == '0);

   // R3: pins outside the address mask keep their value
   p_unmasked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((out_q ^ $past(out_q)) &
                ~($past(win_hit && wr_en) ? $past(pin_mask) : '0)) == '0);

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
   import gpio_port_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  reg_sel_e sel,
   input  logic     wr_en,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] irq_raw,
   input  logic [W-1:0] irq_masked,
   output logic [W-1:0] dir,
   output logic [W-1:0] level_sel,
   output logic [W-1:0] dual_edge,
   output logic [W-1:0] polarity,
   output logic [W-1:0] irq_en,
   output logic [W-1:0] irq_clear,
   output logic [W-1:0] rd_val
);

   localparam reg_sel_e RW_SEL [NUM_RW_REGS] =
      '{SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_POLAR, SEL_ENABLE};

   logic [W-1:0] rw_q [NUM_RW_REGS];

   for (genvar k = 0; k < NUM_RW_REGS; k++) begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        rw_q[k] <= '0;
         else if (wr_en && sel == RW_SEL[k]) rw_q[k] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         irq_clear <= '0;
      else if (wr_en && sel == SEL_CLEAR) irq_clear <= wr_data;
      else                                irq_clear <= '0;
   end

   assign dir       = rw_q[0];
   assign level_sel = rw_q[1];
   assign dual_edge = rw_q[2];
   assign polarity  = rw_q[3];
   assign irq_en    = rw_q[4];

   always_comb begin
      case (sel)
         SEL_DIR:    rd_val = rw_q[0];
         SEL_SENSE:  rd_val = rw_q[1];
         SEL_BOTH:   rd_val = rw_q[2];
         SEL_POLAR:  rd_val = rw_q[3];
         SEL_ENABLE: rd_val = rw_q[4];
         SEL_RAW:    rd_val = irq_raw;
         SEL_MASKED: rd_val = irq_masked;
         default:    rd_val = '0;
      endcase
   end

   // R2: a direction write lands on the next edge
   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DIR) |=> dir == $past(wr_data));

   // R8: writes to the status offsets change no configuration
   p_status_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel == SEL_RAW || sel == SEL_MASKED)) |=>
         ($stable(dir) && $stable(level_sel) && $stable(dual_edge) &&
          $stable(polarity) && $stable(irq_en)));

   // R9: clear pulse only after a clear write, carrying its data
   p_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == SEL_CLEAR) |=> irq_clear == '0);
   p_clear_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CLEAR) |=> irq_clear == $past(wr_data));

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned PINS        = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PINS-1:0]   bus_wdata,
   output logic [PINS-1:0]   bus_rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pin_sync,
   output logic [PINS-1:0]   cfg_level_sel,
   output logic [PINS-1:0]   cfg_dual_edge,
   output logic [PINS-1:0]   cfg_polarity,
   output logic [PINS-1:0]   cfg_irq_en,
   output logic [PINS-1:0]   irq_clear,
   input  logic [PINS-1:0]   irq_raw,
   input  logic [PINS-1:0]   irq_masked
);

   localparam int unsigned MASK_LSB = 2;
   localparam int unsigned MASK_MSB = MASK_LSB + PINS - 1;

   if (PINS != PORT_WIDTH) begin : g_bad_pins
      $error("gpio_masked_port: PINS must equal the register byte width");
   end
   if (ADDR_W < 12 || ADDR_W > 16) begin : g_bad_addr
      $error("gpio_masked_port: ADDR_W must be between 12 and 16");
   end

   logic            in_window;
   logic [PINS-1:0] pin_mask;
   reg_sel_e        sel;
   logic [PINS-1:0] dir;
   logic [PINS-1:0] win_rd;
   logic [PINS-1:0] cfg_rd;

   assign in_window = (bus_addr[ADDR_W-1:WINDOW_TOP_BIT] == '0);
   assign pin_mask  = bus_addr[MASK_MSB:MASK_LSB];
   assign sel       = in_window ? SEL_NONE : decode_offset(16'(bus_addr));

   gpio_pad_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_data_window #(.PINS(PINS)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_hit   (in_window),
      .wr_en     (bus_we),
      .pin_mask  (pin_mask),
      .wr_data   (bus_wdata),
      .dir       (dir),
      .pins_sync (pin_sync),
      .out_q     (pad_out),
      .rd_val    (win_rd)
   );

   gpio_cfg_bank #(.W(PINS)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .wr_en      (bus_we),
      .wr_data    (bus_wdata),
      .irq_raw    (irq_raw),
      .irq_masked (irq_masked),
      .dir        (dir),
      .level_sel  (cfg_level_sel),
      .dual_edge  (cfg_dual_edge),
      .polarity   (cfg_polarity),
      .irq_en     (cfg_irq_en),
      .irq_clear  (irq_clear),
      .rd_val     (cfg_rd)
   );

   assign pad_oe = dir;

   // R11: read data registered one edge after the address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (in_window) bus_rdata <= win_rd;
      else                bus_rdata <= cfg_rd;
   end

   // R5: unmasked bits of a window read are zero
   p_unmasked_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |=> (bus_rdata & ~$past(pin_mask)) == '0);

   // R10: unmapped offsets read zero
   p_unmapped_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_window && sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: tb/gpio_masked_port_test.sv
module gpio_masked_port_test;

   typedef struct {
      int         due;
      logic [7:0] exp;
      string      tag;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out, pad_oe, pin_sync;
   logic [7:0]  cfg_level_sel, cfg_dual_edge, cfg_polarity, cfg_irq_en;
   logic [7:0]  irq_clear;
   logic [7:0]  irq_raw = '0;
   logic [7:0]  irq_masked = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   sb_item_t sb[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   gpio_masked_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync),
      .cfg_level_sel(cfg_level_sel), .cfg_dual_edge(cfg_dual_edge),
      .cfg_polarity(cfg_polarity), .cfg_irq_en(cfg_irq_en),
      .irq_clear(irq_clear), .irq_raw(irq_raw), .irq_masked(irq_masked)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: compare read data against the scoreboard at its due cycle
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
         sb_item_t it;
         it = sb.pop_front();
         check(it.tag, bus_rdata, it.exp);
      end
   end

   // all tasks are entered at a negedge and return at the next one
   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
      bus_addr = a; bus_we = 1'b0;
      sb.push_back('{due: cyc + 1, exp: exp, tag: tag});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 rdata", bus_rdata, 8'h00);
      check("R1 pad_out", pad_out, 8'h00);
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 cfg_level_sel", cfg_level_sel, 8'h00);
      check("R1 cfg_irq_en", cfg_irq_en, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(12'h400, 8'h00, "R1 dir read");
      rd(12'h410, 8'h00, "R1 enable read");

      // R2: direction register
      wr(12'h400, 8'h0F);
      check("R2 pad_oe", pad_oe, 8'h0F);
      rd(12'h400, 8'h0F, "R2 dir readback");

      // R3: masked writes on output pins
      wr(12'h3FC, 8'hA5);
      check("R3 full mask write", pad_out, 8'h05);
      wr(12'h004, 8'h00);
      check("R3 pin0 only", pad_out, 8'h04);
      wr(12'h018, 8'hFF);
      check("R3 pins1-2 only", pad_out, 8'h06);
      check("R3 dir untouched", pad_oe, 8'h0F);

      // R4: input pins ignore data writes
      wr(12'h3FC, 8'hFF);
      check("R4 inputs unchanged", pad_out, 8'h0F);
      wr(12'h400, 8'hFF);
      check("R4 value kept after switch", pad_out, 8'h0F);
      wr(12'h080, 8'hFF);
      check("R4 rewrite after switch", pad_out, 8'h2F);

      // R6: output pins read back their driven value
      pad_in = 8'h00;
      idle(3);
      rd(12'h3FC, 8'h2F, "R6 output readback");

      // R5 and R6: mixed directions and partial masks
      wr(12'h400, 8'h0F);
      pad_in = 8'h5A;
      idle(3);
      rd(12'h3FC, 8'h5F, "R6 mixed read");
      rd(12'h030, 8'h0C, "R5 mask pins2-3");
      rd(12'h0C0, 8'h10, "R5 mask pins4-5");
      rd(12'h000, 8'h00, "R5 empty mask");

      // R6 and R11: synchronizer latency
      wr(12'h400, 8'h00);
      pad_in = 8'hA5;
      rd(12'h3FC, 8'h5A, "R6 sync edge1");
      rd(12'h3FC, 8'h5A, "R6 sync edge2");
      rd(12'h3FC, 8'hA5, "R11 sync edge3");
      check("R6 pin_sync", pin_sync, 8'hA5);

      // R7: interrupt configuration bytes
      wr(12'h404, 8'h11);
      wr(12'h408, 8'h22);
      wr(12'h40C, 8'h44);
      wr(12'h410, 8'h88);
      check("R7 level_sel", cfg_level_sel, 8'h11);
      check("R7 dual_edge", cfg_dual_edge, 8'h22);
      check("R7 polarity", cfg_polarity, 8'h44);
      check("R7 irq_en", cfg_irq_en, 8'h88);
      rd(12'h404, 8'h11, "R7 level read");
      rd(12'h40C, 8'h44, "R7 polarity read");

      // R8: status bytes are read only
      irq_raw = 8'h3C;
      irq_masked = 8'h18;
      rd(12'h414, 8'h3C, "R8 raw read");
      rd(12'h418, 8'h18, "R8 masked read");
      wr(12'h414, 8'hFF);
      wr(12'h418, 8'hFF);
      rd(12'h414, 8'h3C, "R8 raw after write");
      check("R8 cfg intact", cfg_irq_en, 8'h88);
      check("R8 dir intact", pad_oe, 8'h00);

      // R9: clear pulse
      check("R9 idle", irq_clear, 8'h00);
      wr(12'h41C, 8'h81);
      check("R9 pulse", irq_clear, 8'h81);
      @(negedge clk);
      check("R9 pulse ends", irq_clear, 8'h00);
      rd(12'h41C, 8'h00, "R9 clear reads zero");

      // R10: unmapped offsets
      wr(12'h420, 8'hFF);
      wr(12'h402, 8'hFF);
      wr(12'h804, 8'hFF);
      rd(12'h420, 8'h00, "R10 read 0x420");
      rd(12'h406, 8'h00, "R10 read misaligned");
      rd(12'h804, 8'h00, "R10 read 0x804");
      rd(12'h400, 8'h00, "R10 dir intact");
      rd(12'h404, 8'h11, "R10 level intact");
      check("R10 pad_out intact", pad_out, 8'h2F);

      idle(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule